// File: doc/BRIEF.md
# Floating-Point Compare-With-Zero Unit

This unit decides how one extended-precision floating-point value relates to zero and reports the outcome as a four-bit condition code plus three exception flags. The value comes from the top slot of a floating-point register stack. A separate input says whether that slot holds anything.

On a start strobe the unit first sorts the encoding into one of six classes: zero, normal, denormal, infinity, NaN, or an encoding the format does not support. It then picks the condition code and flags. The result is captured in registers and announced by a one-cycle done pulse. It stays on the outputs until the next start.

The field widths are parameters, and so is the choice between an explicit integer bit and an implied one. By default the operand is 80 bits wide: sign at bit 79, a 15-bit biased exponent at bits 78:64, an explicit integer bit at bit 63 and a 63-bit fraction at bits 62:0.

Top module: `fp_zero_cmp`

## Requirements
- R1: A positive finite nonzero operand of a supported encoding gives cond_o = 4'b0000 and raises no flag.
- R2: A negative finite nonzero operand of a supported encoding gives cond_o = 4'b0001 and raises no flag.
- R3: An operand with zero exponent and zero significand (integer bit and fraction both clear) gives cond_o = 4'b1000 whatever its sign, with no flag raised.
- R4: An all-ones exponent with the integer bit set and a nonzero fraction (NaN) gives the unordered code cond_o = 4'b1101 and raises inv_o.
- R5: Unsupported encodings give cond_o = 4'b1101 and raise inv_o. These are a nonzero exponent with the integer bit clear, which covers unnormals and the pseudo-NaN and pseudo-infinity forms at the all-ones exponent.
- R6: A zero exponent with a nonzero significand is a denormal, and this includes a set integer bit. A denormal raises den_o and is compared by its sign (4'b0000 or 4'b0001), so it never gives 4'b1000.
- R7: An all-ones exponent with the integer bit set and a zero fraction (infinity) is compared by its sign and raises no flag.
- R8: When slot_empty_i is high at start, cond_o = 4'b1101 and both inv_o and stk_o are raised, with den_o low, whatever the operand.
- R9: Bit 1 of cond_o is 0 in every result. The code is {equal, unordered, 0, less}.
- R10: Results and flags appear on the clock edge that samples start_i high, and done_o is high for exactly the cycle that follows each such edge.
- R11: While start_i is low, cond_o and the flags keep their last values, even if the operand or the empty tag changes. After reset they are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts one compare on this cycle |
| slot_empty_i | input | 1 | Top stack slot holds no value |
| operand_i | input | 1+EXP_W+MAN_W | Operand: sign, biased exponent, significand |
| cond_o | output | 4 | Condition code {equal, unordered, 0, less} |
| inv_o | output | 1 | Invalid-operand flag |
| den_o | output | 1 | Denormal-operand flag |
| stk_o | output | 1 | Stack-fault flag |
| done_o | output | 1 | One-cycle result-valid pulse |

## Verification
Every result, flag and done pulse is due at the single rising edge that sees start_i high. The bench drives start and the operand on a falling edge and reads the outputs on the next falling edge, half a period after that one capture edge. It then drops start, changes the operand and the empty tag, and reads again one falling edge later. At that point done must be low and the earlier result must be unchanged. A small configuration is swept over every operand code with the slot both full and empty. A few directed vectors check the full 80-bit layout.

// File: rtl/fcz_pkg.sv
package fcz_pkg;

   typedef enum logic [2:0] {
      FC_ZERO,
      FC_NORM,
      FC_DENORM,
      FC_INF,
      FC_NAN,
      FC_UNSUP
   } fcz_class_e;

   // condition code layout: {equal, unordered, always-zero, less}
   localparam logic [3:0] CC_GT = 4'b0000;
   localparam logic [3:0] CC_LT = 4'b0001;
   localparam logic [3:0] CC_EQ = 4'b1000;
   localparam logic [3:0] CC_UN = 4'b1101;

   typedef struct packed {
      logic [3:0] cc;
      logic       inv;
      logic       den;
      logic       stk;
   } fcz_res_t;

endpackage

// File: rtl/fcz_classify.sv
module fcz_classify
   import fcz_pkg::*;
#(
   parameter int EXP_W   = 15,
   parameter int MAN_W   = 64,
   parameter bit INT_BIT = 1'b1
) (
   input  logic [EXP_W-1:0] exp_i,
   input  logic [MAN_W-1:0] man_i,
   output fcz_class_e       cls_o
);

   logic exp_zero;
   logic exp_ones;

   assign exp_zero = (exp_i == '0);
   assign exp_ones = (exp_i == '1);

   generate
      if (INT_BIT) begin : g_explicit
         logic int_b;
         logic frac_nz;

         assign int_b   = man_i[MAN_W-1];
         assign frac_nz = |man_i[MAN_W-2:0];

         always_comb begin
            if (exp_ones) begin
               if (!int_b)       cls_o = FC_UNSUP;
               else if (frac_nz) cls_o = FC_NAN;
               else              cls_o = FC_INF;
            end else if (exp_zero) begin
               if (int_b || frac_nz) cls_o = FC_DENORM;
               else                  cls_o = FC_ZERO;
            end else begin
               cls_o = int_b ? FC_NORM : FC_UNSUP;
            end
         end
      end else begin : g_implicit
         logic frac_nz;

         assign frac_nz = |man_i;

         always_comb begin
            if (exp_ones)      cls_o = frac_nz ? FC_NAN : FC_INF;
            else if (exp_zero) cls_o = frac_nz ? FC_DENORM : FC_ZERO;
            else               cls_o = FC_NORM;
         end
      end
   endgenerate

endmodule

// File: rtl/fcz_decide.sv
module fcz_decide
   import fcz_pkg::*;
(
   input  fcz_class_e cls_i,
   input  logic       sign_i,
   input  logic       empty_i,
   output fcz_res_t   res_o
);

   always_comb begin
      res_o = '{cc: CC_GT, inv: 1'b0, den: 1'b0, stk: 1'b0};
      if (empty_i) begin
         res_o.cc  = CC_UN;
         res_o.inv = 1'b1;
         res_o.stk = 1'b1;
      end else begin
         unique case (cls_i)
            FC_ZERO:   res_o.cc = CC_EQ;
            FC_NAN,
            FC_UNSUP: begin
               res_o.cc  = CC_UN;
               res_o.inv = 1'b1;
            end
            FC_DENORM: begin
               res_o.cc  = sign_i ? CC_LT : CC_GT;
               res_o.den = 1'b1;
            end
            default:   res_o.cc = sign_i ? CC_LT : CC_GT;
         endcase
      end
   end

   // R9
   always_comb begin
      c1_clear_chk : assert (res_o.cc[1] == 1'b0);
   end

endmodule

// File: rtl/fp_zero_cmp.sv
module fp_zero_cmp
   import fcz_pkg::*;
#(
   parameter int EXP_W   = 15,
   parameter int MAN_W   = 64,
   parameter bit INT_BIT = 1'b1,
   localparam int OP_W   = 1 + EXP_W + MAN_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            slot_empty_i,
   input  logic [OP_W-1:0] operand_i,
   output logic [3:0]      cond_o,
   output logic            inv_o,
   output logic            den_o,
   output logic            stk_o,
   output logic            done_o
);

   localparam int SIGN_POS = OP_W - 1;
   localparam int EXP_LSB  = MAN_W;

   generate
      if (EXP_W < 2) begin : g_bad_exp
         $error("fp_zero_cmp: EXP_W must be at least 2");
      end
      if (INT_BIT && MAN_W < 2) begin : g_bad_man
         $error("fp_zero_cmp: MAN_W must be at least 2 with an explicit integer bit");
      end
   endgenerate

   fcz_class_e cls;
   fcz_res_t   res_d;
   fcz_res_t   res_q;
   logic       done_q;

   fcz_classify #(
      .EXP_W   (EXP_W),
      .MAN_W   (MAN_W),
      .INT_BIT (INT_BIT)
   ) u_classify (
      .exp_i (operand_i[EXP_LSB +: EXP_W]),
      .man_i (operand_i[MAN_W-1:0]),
      .cls_o (cls)
   );

   fcz_decide u_decide (
      .cls_i   (cls),
      .sign_i  (operand_i[SIGN_POS]),
      .empty_i (slot_empty_i),
      .res_o   (res_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= start_i;
         if (start_i) res_q <= res_d;
      end
   end

   assign cond_o = res_q.cc;
   assign inv_o  = res_q.inv;
   assign den_o  = res_q.den;
   assign stk_o  = res_q.stk;
   assign done_o = done_q;

   // R10
   done_pulse_chk : assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> !done_o);

   // R10
   done_follow_chk : assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> done_o);

   // R11
   hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> ($stable(cond_o) && $stable(inv_o) && $stable(den_o) && $stable(stk_o)));

   // R8
   empty_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && slot_empty_i) |=> (cond_o == CC_UN && inv_o && stk_o && !den_o));

   // R4
   unord_inv_chk : assert property (@(posedge clk) disable iff (!rst_n)
      cond_o[2] |-> (cond_o[3] && cond_o[0] && inv_o));

   // R6
   denorm_neq_chk : assert property (@(posedge clk) disable iff (!rst_n)
      den_o |-> (!cond_o[3] && !cond_o[2] && !inv_o));

   // R9
   c1_zero_chk : assert property (@(posedge clk) disable iff (!rst_n)
      !cond_o[1]);

endmodule

// File: tb/fp_zero_cmp_tb.sv
module fp_zero_cmp_tb;

   localparam int CLK_PERIOD = 10;
   localparam int SE_W = 3;
   localparam int SM_W = 4;
   localparam int SOP_W = 1 + SE_W + SM_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   // small exhaustive configuration
   logic             start_s = 1'b0;
   logic             empty_s = 1'b0;
   logic [SOP_W-1:0] op_s = '0;
   logic [3:0]       cc_s;
   logic             inv_s, den_s, stk_s, done_s;

   fp_zero_cmp #(.EXP_W(SE_W), .MAN_W(SM_W), .INT_BIT(1'b1)) u_dut (
      .clk (clk), .rst_n (rst_n), .start_i (start_s), .slot_empty_i (empty_s),
      .operand_i (op_s), .cond_o (cc_s), .inv_o (inv_s), .den_o (den_s),
      .stk_o (stk_s), .done_o (done_s)
   );

   // default 80-bit configuration
   logic        start_w = 1'b0;
   logic        empty_w = 1'b0;
   logic [79:0] op_w = '0;
   logic [3:0]  cc_w;
   logic        inv_w, den_w, stk_w, done_w;

   fp_zero_cmp u_dut_wide (
      .clk (clk), .rst_n (rst_n), .start_i (start_w), .slot_empty_i (empty_w),
      .operand_i (op_w), .cond_o (cc_w), .inv_o (inv_w), .den_o (den_w),
      .stk_o (stk_w), .done_o (done_w)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   // expected {cc[3:0], inv, den, stk} for the small layout:
   // [7] sign, [6:4] exponent, [3] integer bit, [2:0] fraction
   function automatic logic [6:0] model(input logic [7:0] op, input logic empty, output string tag);
      logic       s  = op[7];
      logic [2:0] e  = op[6:4];
      logic       ib = op[3];
      logic [2:0] f  = op[2:0];
      logic [3:0] by_sign = s ? 4'b0001 : 4'b0000;
      if (empty) begin
         tag = "R8"; return {4'b1101, 3'b101};
      end
      if (e == 3'd7) begin
         if (!ib)        begin tag = "R5"; return {4'b1101, 3'b100}; end
         if (f != 3'd0)  begin tag = "R4"; return {4'b1101, 3'b100}; end
         tag = "R7"; return {by_sign, 3'b000};
      end
      if (e == 3'd0) begin
         if (!ib && f == 3'd0) begin tag = "R3"; return {4'b1000, 3'b000}; end
         tag = "R6"; return {by_sign, 3'b010};
      end
      if (!ib) begin tag = "R5"; return {4'b1101, 3'b100}; end
      tag = s ? "R2" : "R1";
      return {by_sign, 3'b000};
   endfunction

   task automatic run_wide(input string tag, input logic [79:0] op, input logic empty,
                           input logic [6:0] exp);
      @(negedge clk);
      op_w = op; empty_w = empty; start_w = 1'b1;
      @(negedge clk);
      start_w = 1'b0;
      chk({tag, " wide"}, {1'b0, cc_w, inv_w, den_w, stk_w}, {1'b0, exp});
      chk("R10 wide done", {7'd0, done_w}, 8'd1);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11 reset", {1'b0, cc_s, inv_s, den_s, stk_s}, 8'd0);
      chk("R10 reset done", {7'd0, done_s}, 8'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int em = 0; em < 2; em++) begin
         for (int v = 0; v < (1 << SOP_W); v++) begin
            string      tag;
            logic [6:0] exp;
            exp = model(8'(v), em[0], tag);
            op_s = 8'(v); empty_s = em[0]; start_s = 1'b1;
            @(negedge clk);
            chk(tag, {1'b0, cc_s, inv_s, den_s, stk_s}, {1'b0, exp});
            // R9
            chk("R9", {7'd0, cc_s[1]}, 8'd0);
            // R10
            chk("R10 done high", {7'd0, done_s}, 8'd1);
            start_s = 1'b0; op_s = ~op_s; empty_s = ~empty_s;
            @(negedge clk);
            chk("R10 done low", {7'd0, done_s}, 8'd0);
            chk("R11 hold", {1'b0, cc_s, inv_s, den_s, stk_s}, {1'b0, exp});
         end
      end

      // default layout: sign 79, exponent 78:64, integer bit 63, fraction 62:0
      run_wide("R1 +1.0",           {1'b0, 15'h3FFF, 1'b1, 63'd0}, 1'b0, {4'b0000, 3'b000});
      run_wide("R2 -2.5",           {1'b1, 15'h4000, 1'b1, 63'h2000_0000_0000_0000}, 1'b0, {4'b0001, 3'b000});
      run_wide("R3 -0",             {1'b1, 15'h0000, 1'b0, 63'd0}, 1'b0, {4'b1000, 3'b000});
      run_wide("R4 qnan",           {1'b0, 15'h7FFF, 1'b1, 63'h4000_0000_0000_0000}, 1'b0, {4'b1101, 3'b100});
      run_wide("R5 pseudo-inf",     {1'b1, 15'h7FFF, 1'b0, 63'd0}, 1'b0, {4'b1101, 3'b100});
      run_wide("R5 unnormal",       {1'b0, 15'h1234, 1'b0, 63'd5}, 1'b0, {4'b1101, 3'b100});
      run_wide("R6 pseudo-denorm",  {1'b1, 15'h0000, 1'b1, 63'd1}, 1'b0, {4'b0001, 3'b010});
      run_wide("R7 -inf",           {1'b1, 15'h7FFF, 1'b1, 63'd0}, 1'b0, {4'b0001, 3'b000});
      run_wide("R8 empty",          {1'b0, 15'h0000, 1'b1, 63'd1}, 1'b1, {4'b1101, 3'b101});

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule